// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Port

This block is a single-channel, full-duplex serial port that owns the serial clock. One write on the parallel side loads a transmit byte and starts a frame. The block then drives the serial clock for eight bit periods. It shifts the byte out on the data-out line and collects a byte from the data-in line. At the end it presents the received byte together with a one-cycle completion pulse.

Three static controls set up a frame. Clock polarity picks both the level the clock rests at and which clock edge launches data and which one captures it. Bit order picks whether the least or the most significant bit goes first, and the received byte is rebuilt in the same order. Data inversion flips every bit on the wire in both directions. A programmable divider sets the length of each clock half-period in system clock cycles. All of these settings are captured when a frame starts and are held until it ends.

Top module: `csio_master`

## Requirements
- R1: Every frame has exactly 8 bit periods. The serial clock makes 16 transitions: 8 launch edges and 8 capture edges.
- R2: With clock polarity 0, the serial clock rests high whenever no frame is running. Data-out changes only on falling clock edges, and data-in is captured on rising edges.
- R3: With clock polarity 1, the serial clock rests low whenever no frame is running. Data-out changes only on rising clock edges, and data-in is captured on falling edges.
- R4: With bit order 0, bit 0 of the byte travels first. With bit order 1, bit 7 travels first. The received byte is rebuilt so that the first bit captured lands in bit 0 (order 0) or in bit 7 (order 1).
- R5: With data inversion 1, each transmitted bit appears complemented on data-out, and each captured bit is complemented before it is stored. With data inversion 0, data passes unchanged.
- R6: Each serial clock half-period, including the time from frame start to the first edge, lasts divider value + 1 system clock cycles.
- R7: A write strobe while idle starts a frame. In the next cycle busy is high, the clock is still at its resting level, and data-out already carries the first bit. Busy stays high for 16 × (divider + 1) cycles.
- R8: A write strobe while busy is ignored. The frame in progress keeps its data and its length, and no second frame follows.
- R9: On the eighth capture edge, the received byte is updated and the done flag goes high for exactly one cycle. In that same cycle busy is low and the clock is back at its resting level.
- R10: Changing the polarity, bit-order or inversion inputs during a frame has no effect on that frame's clock, data-out bits or received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_clk_pol | input | 1 | Clock polarity: 0 rests high, 1 rests low |
| cfg_msb_first | input | 1 | Bit order: 0 LSB first, 1 MSB first |
| cfg_data_inv | input | 1 | 1 complements serial data in both directions |
| cfg_div | input | DIV_W | Half-period length minus one, in system clock cycles |
| tx_wr | input | 1 | Write strobe; starts a frame when idle |
| tx_byte | input | DATA_W | Byte to transmit, captured with tx_wr |
| rx_byte | output | DATA_W | Last received byte |
| rx_done | output | 1 | One-cycle pulse when a frame completes |
| busy | output | 1 | High while a frame is running |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A corrupted edge counter or divider count shows up at once as a wrong number of clock transitions, or as a half-period of the wrong length. It also moves the busy fall and the done pulse away from the expected cycle, which can be exact-counted within a single frame. A wrong shift-register or captured-setting value appears as a data-out bit that differs from the expected wire bit, or as a wrong received byte. This is visible at the first affected capture edge or at frame end. A stray start, or a lost ignore of a write while busy, changes the busy length, which is checked for every frame.

// File: rtl/csio_pkg.sv
package csio_pkg;

   // Settings captured at frame start
   typedef struct packed {
      logic clk_pol;    // 0: clock rests high, 1: clock rests low
      logic msb_first;  // 0: bit 0 first, 1: top bit first
      logic data_inv;   // 1: complement wire data both ways
   } csio_cfg_t;

   localparam int unsigned CSIO_EDGES_PER_BIT = 2;

endpackage

// File: rtl/csio_baud.sv
module csio_baud #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_live,
   input  logic [DIV_W-1:0] div_hold,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   // While idle the counter preloads, so the first edge comes a full half-period after start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= div_live;
      end else if (cnt_q == '0) begin
         cnt_q <= div_hold;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/csio_ctrl.sv
module csio_ctrl
   import csio_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 8,
   parameter int unsigned DIV_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  csio_cfg_t        cfg_live,
   input  logic [DIV_W-1:0] div_live,
   input  logic             tick,
   output logic             busy,
   output csio_cfg_t        cfg_q,
   output logic [DIV_W-1:0] div_q,
   output logic             sclk,
   output logic             load,
   output logic             shift_en,
   output logic             sample_en,
   output logic             last
);

   localparam int unsigned EDGES = FRAME_BITS * CSIO_EDGES_PER_BIT;
   localparam int unsigned CNT_W = $clog2(EDGES);
   localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

   logic [CNT_W-1:0] edge_q;
   logic             lead;

   assign load      = wr && !busy;
   // Even edge index: launch edge; odd index: capture edge
   assign lead      = busy && tick && !edge_q[0];
   assign shift_en  = lead && (edge_q != '0);
   assign sample_en = busy && tick && edge_q[0];
   assign last      = sample_en && (edge_q == LAST_EDGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cfg_q  <= '0;
         div_q  <= '0;
         edge_q <= '0;
         sclk   <= 1'b1;
      end else if (load) begin
         busy   <= 1'b1;
         cfg_q  <= cfg_live;
         div_q  <= div_live;
         edge_q <= '0;
         sclk   <= ~cfg_live.clk_pol;
      end else if (busy) begin
         if (tick) begin
            edge_q <= edge_q + 1'b1;
            if (last) begin
               busy <= 1'b0;
               sclk <= ~cfg_q.clk_pol;
            end else begin
               sclk <= ~sclk;
            end
         end
      end else begin
         sclk <= ~cfg_live.clk_pol;
      end
   end

endmodule

// File: rtl/csio_shift.sv
module csio_shift
   import csio_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] load_data,
   input  csio_cfg_t             cfg_live,
   input  csio_cfg_t             cfg_q,
   input  logic                  shift_en,
   input  logic                  sample_en,
   input  logic                  last,
   input  logic                  sdi,
   output logic                  sdo,
   output logic [FRAME_BITS-1:0] rx_data,
   output logic                  rx_done
);

   logic [FRAME_BITS-1:0] tx_sr;
   logic [FRAME_BITS-2:0] rx_sr;
   logic [FRAME_BITS-1:0] load_rev;
   logic [FRAME_BITS-1:0] rx_next;
   logic [FRAME_BITS-1:0] rx_rev;
   logic                  rx_bit;

   // Bit-reversal networks for MSB-first frames
   for (genvar g = 0; g < FRAME_BITS; g++) begin : g_rev
      assign load_rev[g] = load_data[FRAME_BITS-1-g];
      assign rx_rev[g]   = rx_next[FRAME_BITS-1-g];
   end

   assign rx_bit  = sdi ^ cfg_q.data_inv;
   assign rx_next = {rx_bit, rx_sr};
   assign sdo     = tx_sr[0] ^ cfg_q.data_inv;

   // Transmit side: wire bit is always tx_sr[0]
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '1;
      end else if (load) begin
         tx_sr <= cfg_live.msb_first ? load_rev : load_data;
      end else if (shift_en) begin
         tx_sr <= {1'b1, tx_sr[FRAME_BITS-1:1]};
      end
   end

   // Receive side: first captured bit ends up in bit 0 before reordering
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr   <= '0;
         rx_data <= '0;
         rx_done <= 1'b0;
      end else begin
         rx_done <= 1'b0;
         if (sample_en) begin
            rx_sr <= rx_next[FRAME_BITS-1:1];
         end
         if (last) begin
            rx_data <= cfg_q.msb_first ? rx_rev : rx_next;
            rx_done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/csio_master.sv
module csio_master
   import csio_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_clk_pol,
   input  logic              cfg_msb_first,
   input  logic              cfg_data_inv,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_done,
   output logic              busy,
   output logic              sclk,
   output logic              sdo,
   input  logic              sdi
);

   if (DATA_W < 2) begin : g_bad_width
      $error("csio_master: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("csio_master: DIV_W must be at least 1");
   end

   csio_cfg_t        cfg_live;
   csio_cfg_t        cfg_q;
   logic [DIV_W-1:0] div_q;
   logic             tick;
   logic             load;
   logic             shift_en;
   logic             sample_en;
   logic             last;

   assign cfg_live = '{clk_pol: cfg_clk_pol, msb_first: cfg_msb_first, data_inv: cfg_data_inv};

   csio_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div_live (cfg_div),
      .div_hold (div_q),
      .tick     (tick)
   );

   csio_ctrl #(.FRAME_BITS(DATA_W), .DIV_W(DIV_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (tx_wr),
      .cfg_live  (cfg_live),
      .div_live  (cfg_div),
      .tick      (tick),
      .busy      (busy),
      .cfg_q     (cfg_q),
      .div_q     (div_q),
      .sclk      (sclk),
      .load      (load),
      .shift_en  (shift_en),
      .sample_en (sample_en),
      .last      (last)
   );

   csio_shift #(.FRAME_BITS(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (tx_byte),
      .cfg_live  (cfg_live),
      .cfg_q     (cfg_q),
      .shift_en  (shift_en),
      .sample_en (sample_en),
      .last      (last),
      .sdi       (sdi),
      .sdo       (sdo),
      .rx_data   (rx_byte),
      .rx_done   (rx_done)
   );

endmodule

// File: rtl/csio_master_chk.sv
module csio_master_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_clk_pol,
   input logic tx_wr,
   input logic rx_done,
   input logic busy,
   input logic sclk,
   input logic sdo
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2 / R3: resting level follows polarity while idle
   assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !busy && $past(!busy) && $stable(cfg_clk_pol)) |-> (sclk == !cfg_clk_pol));

   // R2 / R3: data-out moves only together with a clock edge
   assert_sdo_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(sdo)) |-> !$stable(sclk));

   // R7: a frame starts only from a write strobe
   assert_start_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tx_wr));

   // R7: the clock has not moved yet in the first busy cycle
   assert_start_idle_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $stable(sclk));

   // R9: done is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R9: done coincides with the end of busy
   assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> rx_done);

   assert_done_needs_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $fell(busy));

endmodule

bind csio_master csio_master_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_clk_pol (cfg_clk_pol),
   .tx_wr       (tx_wr),
   .rx_done     (rx_done),
   .busy        (busy),
   .sclk        (sclk),
   .sdo         (sdo)
);

// File: tb/csio_master_bench.sv
module csio_master_bench;

   localparam int DATA_W = 8;
   localparam int DIV_W  = 8;
   localparam int WD_CYCLES = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_clk_pol = 1'b0;
   logic              cfg_msb_first = 1'b0;
   logic              cfg_data_inv = 1'b0;
   logic [DIV_W-1:0]  cfg_div = '0;
   logic              tx_wr = 1'b0;
   logic [DATA_W-1:0] tx_byte = '0;
   logic [DATA_W-1:0] rx_byte;
   logic              rx_done;
   logic              busy;
   logic              sclk;
   logic              sdo;
   logic              sdi = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   csio_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_csio_master (
      .clk(clk), .rst_n(rst_n), .cfg_clk_pol(cfg_clk_pol), .cfg_msb_first(cfg_msb_first),
      .cfg_data_inv(cfg_data_inv), .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_byte(tx_byte),
      .rx_byte(rx_byte), .rx_done(rx_done), .busy(busy), .sclk(sclk), .sdo(sdo), .sdi(sdi)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic wire_bit(input logic [7:0] b, input int k, input bit msb, input bit inv);
      return (msb ? b[7-k] : b[k]) ^ inv;
   endfunction

   // One full frame; mid_wr issues a write while busy, mid_cfg flips settings mid-frame
   task automatic do_frame(input bit pol, input bit msb, input bit inv, input int div,
                           input logic [7:0] txb, input logic [7:0] slv,
                           input bit mid_wr, input bit mid_cfg, input string req);
      int edges = 0;
      int since = 0;
      int bad_hp = 0;
      int bad_dir = 0;
      int bad_sdo = 0;
      int busy_cnt = 0;
      int cyc = 0;
      logic prev;
      @(negedge clk);
      cfg_clk_pol = pol; cfg_msb_first = msb; cfg_data_inv = inv; cfg_div = DIV_W'(div);
      repeat (2) @(negedge clk);
      chk(sclk == ~pol, pol ? "R3" : "R2", "resting clock level", sclk, ~pol);
      tx_wr = 1'b1; tx_byte = txb;
      @(negedge clk);
      tx_wr = 1'b0;
      chk(busy == 1'b1, "R7", "busy after write", busy, 1);
      chk(sclk == ~pol, "R7", "clock still resting at start", sclk, ~pol);
      chk(sdo == wire_bit(txb, 0, msb, inv), "R7", "first bit present before first edge",
          sdo, wire_bit(txb, 0, msb, inv));
      sdi = wire_bit(slv, 0, msb, inv);
      busy_cnt = 1;
      prev = sclk;
      while (cyc < 5000) begin
         logic prev_sdo;
         prev_sdo = sdo;
         @(negedge clk);
         cyc++;
         since++;
         if (mid_wr && cyc == 5) begin tx_wr = 1'b1; tx_byte = ~txb; end
         if (mid_wr && cyc == 6) tx_wr = 1'b0;
         if (mid_cfg && cyc == 3) begin
            cfg_clk_pol = ~pol; cfg_msb_first = ~msb; cfg_data_inv = ~inv;
         end
         if (sclk != prev) begin
            edges++;
            if (since != div + 1) bad_hp++;
            since = 0;
            if (edges % 2 == 1) begin
               // launch edge: must move toward the active level
               if (sclk != pol) bad_dir++;
               if (edges >= 3) begin
                  if (sdo != wire_bit(txb, (edges - 1) / 2, msb, inv)) bad_sdo++;
                  sdi = wire_bit(slv, (edges - 1) / 2, msb, inv);
               end
            end else begin
               if (sclk == pol) bad_dir++;
               if (sdo != wire_bit(txb, edges / 2 - 1, msb, inv)) bad_sdo++;
            end
         end else if (busy && sdo != prev_sdo) begin
            bad_dir++;
         end
         prev = sclk;
         if (busy) busy_cnt++;
         else break;
      end
      chk(edges == 16, "R1", "clock transitions per frame", edges, 16);
      chk(bad_hp == 0, "R6", "half-periods not equal to divider+1", bad_hp, 0);
      chk(bad_dir == 0, pol ? "R3" : "R2", "edge direction of launch/capture", bad_dir, 0);
      chk(bad_sdo == 0, req, "data-out bit mismatches", bad_sdo, 0);
      chk(busy_cnt == 16 * (div + 1), "R7", "busy length in cycles", busy_cnt, 16 * (div + 1));
      chk(rx_done == 1'b1, "R9", "done at frame end", rx_done, 1);
      chk(rx_byte == slv, req, "received byte", rx_byte, slv);
      chk(sclk == ~pol, "R9", "clock back at rest", sclk, ~pol);
      @(negedge clk);
      chk(rx_done == 1'b0, "R9", "done lasts one cycle", rx_done, 0);
      if (mid_wr) begin
         chk(busy == 1'b0, "R8", "no second frame after ignored write", busy, 0);
         repeat (3) @(negedge clk);
         chk(busy == 1'b0, "R8", "still idle later", busy, 0);
      end
   endtask

   task automatic t_reset;
      chk(sclk == 1'b1, "R2", "reset clock level", sclk, 1);
      chk(busy == 1'b0, "R7", "reset busy", busy, 0);
      chk(rx_done == 1'b0, "R9", "reset done", rx_done, 0);
      chk(rx_byte == 8'h00, "R9", "reset rx byte", rx_byte, 0);
   endtask

   task automatic t_pol0_lsb;   do_frame(0, 0, 0, 3, 8'hA5, 8'h3C, 0, 0, "R4"); endtask
   task automatic t_pol1_lsb;   do_frame(1, 0, 0, 1, 8'h96, 8'hC1, 0, 0, "R3"); endtask
   task automatic t_msb_first;  do_frame(0, 1, 0, 0, 8'h81, 8'h4E, 0, 0, "R4"); endtask
   task automatic t_msb_pol1;   do_frame(1, 1, 0, 2, 8'h1F, 8'hE2, 0, 0, "R4"); endtask
   task automatic t_invert;     do_frame(0, 0, 1, 1, 8'h5A, 8'h0F, 0, 0, "R5"); endtask
   task automatic t_invert_msb; do_frame(1, 1, 1, 7, 8'hC3, 8'hB4, 0, 0, "R5"); endtask
   task automatic t_write_busy; do_frame(0, 0, 0, 2, 8'h6D, 8'h92, 1, 0, "R8"); endtask
   task automatic t_cfg_change; do_frame(0, 0, 0, 3, 8'hE7, 8'h18, 0, 1, "R10"); endtask
   task automatic t_div_edges;  do_frame(1, 0, 1, 0, 8'hFF, 8'h00, 0, 0, "R6"); endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_pol0_lsb();
      t_pol1_lsb();
      t_msb_first();
      t_msb_pol1();
      t_invert();
      t_invert_msb();
      t_write_busy();
      t_cfg_change();
      t_div_edges();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule